// File: doc/BRIEF.md
# JTAG Scan Sequencer Master

This block drives a JTAG target from the master side. It makes TCK from the system clock through a programmable divider, and it drives TMS and TDI. It samples TDO and returns the bits it captured. A host asks for one of three operations: a TAP reset, an instruction-register scan, or a data-register scan. Each request carries a bit count and a vector to shift in. The block walks the target's TAP controller along the matching TMS path and starts and ends every operation in Run-Test/Idle. When the operation is complete, it returns the captured TDO vector together with a one-cycle done pulse.

The target TAP leaves each shift state on the final data bit: TMS is raised in the same TCK cycle that carries the last TDI bit, so no extra shift rolls the target register. The block also remembers whether a reset was the most recent operation that changed the instruction register. While that holds, a data scan is treated as an IDCODE read, and its length is forced to the IDCODE width. The TAP is assumed to be in an unknown state after power-up, so the host issues a reset operation first.

Top module: `jscan_master`

## Requirements
- R1: After system reset, tck_o=1, tms_o=1, tdi_o=0, busy_o=0, done_o=0 and rdata_o=0. TCK stays high whenever busy_o is low.
- R2: One TCK period is TCK_DIV system clocks. TCK falls at the start of the period and rises TCK_DIV/2 clocks later. TMS and TDI change only together with a TCK falling edge. TDO is sampled one system clock before the TCK rising edge.
- R3: A reset operation (cmd_op_i=0) gives RST_TMS_CYCLES TCK rising edges with TMS=1, then exactly one with TMS=0, for RST_TMS_CYCLES+1 rising edges in total. rdata_o is then 0.
- R4: An instruction scan (cmd_op_i=1) gives the TMS sequence 1,1,0,0 before shifting, N shift cycles, then 1,0. That is N+6 rising edges in total, and the target ends in Run-Test/Idle.
- R5: A data scan (cmd_op_i=2) gives the TMS sequence 1,0,0 before shifting, N shift cycles, then 1,0. That is N+5 rising edges in total, and the target ends in Run-Test/Idle.
- R6: TDI carries cmd_tdi_i LSB first, starting at bit 0. The TDO bit captured in shift cycle i is stored in rdata_o[i], and rdata_o bits at and above N are 0.
- R7: TMS is 1 only in the shift cycle that carries bit N-1, so the target sees exactly N shift-state rising edges.
- R8: A data scan issued while no instruction scan has run since the last reset operation uses N=IDCODE_BITS, whatever the value of cmd_len_i. This holds for every such data scan until the next instruction scan.
- R9: A cmd_len_i of 0 gives N=1, and a cmd_len_i above MAX_BITS gives N=MAX_BITS.
- R10: busy_o rises the cycle after a command is accepted and falls in the cycle done_o pulses for one clock. A cmd_valid_i seen while busy_o=1, or a cmd_op_i of 3, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cmd_valid_i | input | 1 | Command request, taken when idle |
| cmd_op_i | input | 2 | 0 reset, 1 instruction scan, 2 data scan, 3 none |
| cmd_len_i | input | $clog2(MAX_BITS+1) | Scan length in bits |
| cmd_tdi_i | input | MAX_BITS | Vector to shift in, LSB first |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | MAX_BITS | Captured TDO vector, LSB first |
| tck_o | output | 1 | Test clock to target |
| tms_o | output | 1 | Test mode select to target |
| tdi_o | output | 1 | Test data to target |
| tdo_i | input | 1 | Test data from target |

## Verification
The bench builds the block with TCK_DIV=6 instead of the default. This tests a divider that is not a power of two, with the sample phase two clocks after the falling edge. MAX_BITS is kept at 64 and IDCODE_BITS at 32. With these values a full-width 64-bit bypass scan, the clamps at 0 and at more than 64 bits, and the forced 32-bit IDCODE read can all be checked against a behavioural TAP model with 4-bit instructions and a 16-bit user register.

// File: rtl/jscan_pkg.sv
package jscan_pkg;

    typedef enum logic [1:0] {
        OP_RST  = 2'd0,
        OP_IR   = 2'd1,
        OP_DR   = 2'd2,
        OP_NONE = 2'd3
    } jop_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_PRE,
        SQ_SHIFT,
        SQ_POST,
        SQ_FIN
    } seq_e;

    // TCK cycles spent before the first shift bit, from Run-Test/Idle
    localparam int IR_PRE_CYCLES = 4;   // Select-DR, Select-IR, Capture-IR, enter Shift-IR
    localparam int DR_PRE_CYCLES = 3;   // Select-DR, Capture-DR, enter Shift-DR

endpackage

// File: rtl/jscan_tck_gen.sv
module jscan_tck_gen #(
    parameter int TCK_DIV = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    output logic tck_o,
    output logic drive_o,
    output logic samp_o,
    output logic rise_o
);

    localparam int PH_W = $clog2(TCK_DIV);
    localparam int HALF = TCK_DIV / 2;

    generate
        if (TCK_DIV < 4) begin : g_div_check
            $error("TCK_DIV must be at least 4");
        end
    endgenerate

    typedef struct packed {
        logic [PH_W-1:0] ph;
        logic            tck;
    } gen_t;

    gen_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (run_i) begin
            g_d.ph = (g_q.ph == PH_W'(TCK_DIV - 1)) ? '0 : g_q.ph + 1'b1;
            if (g_q.ph == '0) begin
                g_d.tck = 1'b0;
            end else if (g_q.ph == PH_W'(HALF)) begin
                g_d.tck = 1'b1;
            end
        end else begin
            g_d.ph  = '0;
            g_d.tck = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            g_q <= '{ph: '0, tck: 1'b1};
        end else begin
            g_q <= g_d;
        end
    end

    assign tck_o   = g_q.tck;
    assign drive_o = run_i && (g_q.ph == '0);
    assign samp_o  = run_i && (g_q.ph == PH_W'(HALF - 1));
    assign rise_o  = run_i && (g_q.ph == PH_W'(HALF));

    AST_LOW_AT_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        samp_o |-> !tck_o);  // R2

endmodule

// File: rtl/jscan_shifter.sv
module jscan_shifter #(
    parameter int MAX_BITS = 64
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                load_i,
    input  logic [MAX_BITS-1:0] tx_i,
    input  logic                shift_i,
    input  logic                samp_i,
    input  logic                tdo_i,
    output logic                tdi_o,
    output logic [MAX_BITS-1:0] rx_o
);

    localparam int IDX_W = $clog2(MAX_BITS + 1);
    localparam int BIT_W = $clog2(MAX_BITS);

    typedef struct packed {
        logic [MAX_BITS-1:0] tx;
        logic [MAX_BITS-1:0] rx;
        logic [IDX_W-1:0]    idx;
        logic                pend;
        logic                tdi;
    } shf_t;

    shf_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load_i) begin
            s_d.tx   = tx_i;
            s_d.rx   = '0;
            s_d.idx  = '0;
            s_d.pend = 1'b0;
        end else begin
            // R6: next TDI bit leaves from the LSB end
            if (shift_i) begin
                s_d.tdi  = s_q.tx[0];
                s_d.tx   = s_q.tx >> 1;
                s_d.pend = 1'b1;
            end
            // R6: captured bit lands at its shift position
            if (samp_i && s_q.pend) begin
                if (s_q.idx < IDX_W'(MAX_BITS)) begin
                    s_d.rx[s_q.idx[BIT_W-1:0]] = tdo_i;
                end
                s_d.idx  = s_q.idx + 1'b1;
                s_d.pend = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tdi_o = s_q.tdi;
    assign rx_o  = s_q.rx;

    AST_IDX_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.idx <= IDX_W'(MAX_BITS));  // R9

    AST_SAMPLE_AFTER_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (samp_i && !load_i) |-> (s_q.pend || !$past(shift_i)));  // R7

endmodule

// File: rtl/jscan_seq.sv
module jscan_seq
    import jscan_pkg::*;
#(
    parameter int MAX_BITS       = 64,
    parameter int IDCODE_BITS    = 32,
    parameter int RST_TMS_CYCLES = 5,
    localparam int LEN_W         = $clog2(MAX_BITS + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cmd_valid_i,
    input  logic [1:0]       cmd_op_i,
    input  logic [LEN_W-1:0] cmd_len_i,
    input  logic             drive_i,
    input  logic             rise_i,
    output logic             run_o,
    output logic             tms_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             load_o,
    output logic             shift_o
);

    typedef struct packed {
        seq_e             st;
        jop_e             op;
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] cnt;
        logic             fresh;
        logic             run;
        logic             tms;
        logic             done;
    } seq_t;

    seq_t s_d, s_q;

    jop_e             req_op;
    logic             accept;
    logic [LEN_W-1:0] eff_len;
    logic [LEN_W-1:0] pre_len;
    logic             pre_tms;

    assign req_op = jop_e'(cmd_op_i);
    assign accept = (s_q.st == SQ_IDLE) && cmd_valid_i && (req_op != OP_NONE);  // R10

    // R8, R9: effective scan length
    always_comb begin
        if (req_op == OP_DR && s_q.fresh) begin
            eff_len = LEN_W'(IDCODE_BITS);
        end else if (cmd_len_i == '0) begin
            eff_len = LEN_W'(1);
        end else if (cmd_len_i > LEN_W'(MAX_BITS)) begin
            eff_len = LEN_W'(MAX_BITS);
        end else begin
            eff_len = cmd_len_i;
        end
    end

    // TMS path ahead of the shift: R3 all ones, R4 1,1,0,0, R5 1,0,0
    always_comb begin
        unique case (s_q.op)
            OP_RST: begin
                pre_len = LEN_W'(RST_TMS_CYCLES);
                pre_tms = 1'b1;
            end
            OP_IR: begin
                pre_len = LEN_W'(IR_PRE_CYCLES);
                pre_tms = (s_q.cnt < LEN_W'(2));
            end
            default: begin
                pre_len = LEN_W'(DR_PRE_CYCLES);
                pre_tms = (s_q.cnt == '0);
            end
        endcase
    end

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.st)
            SQ_IDLE: begin
                if (accept) begin
                    s_d.op  = req_op;
                    s_d.len = eff_len;
                    s_d.cnt = '0;
                    s_d.run = 1'b1;
                    s_d.st  = SQ_PRE;
                end
            end
            SQ_PRE: begin
                if (drive_i) begin
                    s_d.tms = pre_tms;
                    if (s_q.cnt == pre_len - 1'b1) begin
                        s_d.cnt = '0;
                        s_d.st  = (s_q.op == OP_RST) ? SQ_POST : SQ_SHIFT;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
            end
            SQ_SHIFT: begin
                if (drive_i) begin
                    // R7: leave the shift state on the final bit
                    s_d.tms = (s_q.cnt == s_q.len - 1'b1);
                    if (s_q.cnt == s_q.len - 1'b1) begin
                        s_d.cnt = '0;
                        s_d.st  = SQ_POST;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
            end
            SQ_POST: begin
                if (drive_i) begin
                    // scans: Exit1 -> Update (1), Update -> Run-Test/Idle (0); reset: 0
                    s_d.tms = (s_q.op != OP_RST) && (s_q.cnt == '0);
                    if (s_q.op == OP_RST || s_q.cnt == LEN_W'(1)) begin
                        s_d.st = SQ_FIN;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
            end
            SQ_FIN: begin
                if (rise_i) begin
                    s_d.run  = 1'b0;
                    s_d.done = 1'b1;
                    s_d.st   = SQ_IDLE;
                    if (s_q.op == OP_RST) begin
                        s_d.fresh = 1'b1;
                    end else if (s_q.op == OP_IR) begin
                        s_d.fresh = 1'b0;
                    end
                end
            end
            default: s_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '{st: SQ_IDLE, op: OP_NONE, len: '0, cnt: '0,
                     fresh: 1'b0, run: 1'b0, tms: 1'b1, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign run_o   = s_q.run;
    assign tms_o   = s_q.tms;
    assign busy_o  = (s_q.st != SQ_IDLE);
    assign done_o  = s_q.done;
    assign load_o  = accept;
    assign shift_o = drive_i && (s_q.st == SQ_SHIFT);

    AST_IGNORE_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && cmd_valid_i) |=> $stable(s_q.op) && $stable(s_q.len));  // R10

    AST_LEN_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> (s_q.len >= LEN_W'(1) || s_q.op == OP_RST) && s_q.len <= LEN_W'(MAX_BITS));  // R9

endmodule

// File: rtl/jscan_master.sv
module jscan_master
    import jscan_pkg::*;
#(
    parameter int MAX_BITS       = 64,
    parameter int TCK_DIV        = 4,
    parameter int IDCODE_BITS    = 32,
    parameter int RST_TMS_CYCLES = 5,
    localparam int LEN_W         = $clog2(MAX_BITS + 1)
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                cmd_valid_i,
    input  logic [1:0]          cmd_op_i,
    input  logic [LEN_W-1:0]    cmd_len_i,
    input  logic [MAX_BITS-1:0] cmd_tdi_i,
    output logic                busy_o,
    output logic                done_o,
    output logic [MAX_BITS-1:0] rdata_o,
    output logic                tck_o,
    output logic                tms_o,
    output logic                tdi_o,
    input  logic                tdo_i
);

    logic run;
    logic drive_stb;
    logic samp_stb;
    logic rise_stb;
    logic load;
    logic shift_stb;

    jscan_tck_gen #(
        .TCK_DIV (TCK_DIV)
    ) u_tck_gen (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (run),
        .tck_o   (tck_o),
        .drive_o (drive_stb),
        .samp_o  (samp_stb),
        .rise_o  (rise_stb)
    );

    jscan_seq #(
        .MAX_BITS       (MAX_BITS),
        .IDCODE_BITS    (IDCODE_BITS),
        .RST_TMS_CYCLES (RST_TMS_CYCLES)
    ) u_seq (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cmd_valid_i (cmd_valid_i),
        .cmd_op_i    (cmd_op_i),
        .cmd_len_i   (cmd_len_i),
        .drive_i     (drive_stb),
        .rise_i      (rise_stb),
        .run_o       (run),
        .tms_o       (tms_o),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .load_o      (load),
        .shift_o     (shift_stb)
    );

    jscan_shifter #(
        .MAX_BITS (MAX_BITS)
    ) u_shifter (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (load),
        .tx_i    (cmd_tdi_i),
        .shift_i (shift_stb),
        .samp_i  (samp_stb),
        .tdo_i   (tdo_i),
        .tdi_o   (tdi_o),
        .rx_o    (rdata_o)
    );

    AST_TCK_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> tck_o);  // R1

    AST_TMS_MOVES_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(tms_o) |-> $fell(tck_o));  // R2

    AST_TDI_MOVES_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(tdi_o) |-> $fell(tck_o));  // R2

    AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);  // R10

    AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> done_o);  // R10

endmodule

// File: tb/jscan_master_tb_top.sv
module jscan_master_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 6;
    localparam int MAXB       = 64;
    localparam int WDOG       = 150000;
    localparam logic [63:0] IDC = 64'h0000_0000_1B57_C0DF;

    // behavioural TAP state numbers
    localparam int S_TLR = 0, S_RTI = 1, S_SELDR = 2, S_CAPDR = 3, S_SHDR = 4,
                   S_EX1DR = 5, S_PAUDR = 6, S_EX2DR = 7, S_UPDR = 8, S_SELIR = 9,
                   S_CAPIR = 10, S_SHIR = 11, S_EX1IR = 12, S_PAUIR = 13,
                   S_EX2IR = 14, S_UPIR = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [6:0]  cmd_len = 7'd0;
    logic [63:0] cmd_tdi = 64'd0;
    logic        busy, done, tck, tms, tdi;
    logic        tdo = 1'b0;
    logic [63:0] rdata;

    always #(CLK_PERIOD / 2) clk = ~clk;

    jscan_master #(
        .MAX_BITS       (MAXB),
        .TCK_DIV        (DIV),
        .IDCODE_BITS    (32),
        .RST_TMS_CYCLES (5)
    ) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .cmd_valid_i (cmd_valid),
        .cmd_op_i    (cmd_op),
        .cmd_len_i   (cmd_len),
        .cmd_tdi_i   (cmd_tdi),
        .busy_o      (busy),
        .done_o      (done),
        .rdata_o     (rdata),
        .tck_o       (tck),
        .tms_o       (tms),
        .tdi_o       (tdi),
        .tdo_i       (tdo)
    );

    // ---------------- behavioural target TAP ----------------
    int          ts = S_SHDR;
    logic [3:0]  ir = 4'h1;
    logic [63:0] ir_sr = '0;
    logic [63:0] dr_sr = '0;
    int          dr_len = 1;
    logic [15:0] dreg = '0;
    int          rise_cnt = 0;
    int          shift_cnt = 0;
    logic [7:0]  tms_hist = '0;
    int          cyc = 0;
    int          last_rise = 0;
    int          period = 0;

    function automatic int tap_next(input int s, input logic m);
        case (s)
            S_TLR:   return m ? S_TLR   : S_RTI;
            S_RTI:   return m ? S_SELDR : S_RTI;
            S_SELDR: return m ? S_SELIR : S_CAPDR;
            S_CAPDR: return m ? S_EX1DR : S_SHDR;
            S_SHDR:  return m ? S_EX1DR : S_SHDR;
            S_EX1DR: return m ? S_UPDR  : S_PAUDR;
            S_PAUDR: return m ? S_EX2DR : S_PAUDR;
            S_EX2DR: return m ? S_UPDR  : S_SHDR;
            S_UPDR:  return m ? S_SELDR : S_RTI;
            S_SELIR: return m ? S_TLR   : S_CAPIR;
            S_CAPIR: return m ? S_EX1IR : S_SHIR;
            S_SHIR:  return m ? S_EX1IR : S_SHIR;
            S_EX1IR: return m ? S_UPIR  : S_PAUIR;
            S_PAUIR: return m ? S_EX2IR : S_PAUIR;
            S_EX2IR: return m ? S_UPIR  : S_SHIR;
            default: return m ? S_SELDR : S_RTI;
        endcase
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge tck) begin
        rise_cnt  = rise_cnt + 1;
        tms_hist  = {tms_hist[6:0], tms};
        period    = cyc - last_rise;
        last_rise = cyc;
        case (ts)
            S_TLR: begin ir = 4'h1; dreg = '0; end
            S_CAPIR: ir_sr = 64'h5;
            S_SHIR: begin
                ir_sr = (ir_sr >> 1) | ({63'd0, tdi} << 3);
                shift_cnt = shift_cnt + 1;
            end
            S_UPIR: ir = ir_sr[3:0];
            S_CAPDR: begin
                if (ir == 4'h1) begin dr_sr = IDC; dr_len = 32; end
                else if (ir == 4'h3) begin dr_sr = {48'd0, dreg}; dr_len = 16; end
                else begin dr_sr = '0; dr_len = 1; end
            end
            S_SHDR: begin
                dr_sr = (dr_sr >> 1) | ({63'd0, tdi} << (dr_len - 1));
                shift_cnt = shift_cnt + 1;
            end
            S_UPDR: if (ir == 4'h3) dreg = dr_sr[15:0];
            default: ;
        endcase
        ts = tap_next(ts, tms);
    end

    always @(negedge tck) begin
        if (ts == S_SHIR)      tdo = ir_sr[0];
        else if (ts == S_SHDR) tdo = dr_sr[0];
        else                   tdo = 1'b0;
    end

    // ---------------- checking ----------------
    int n_chk = 0;
    int n_fail = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] op, input logic [6:0] len,
                          input logic [63:0] v, output logic [63:0] rd,
                          output bit timed_out);
        int t;
        @(negedge clk);
        rise_cnt  = 0;
        shift_cnt = 0;
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_len   = len;
        cmd_tdi   = v;
        @(negedge clk);
        cmd_valid = 1'b0;
        t = 0;
        while (!done && t < 20000) begin
            @(negedge clk);
            t++;
        end
        timed_out = (t >= 20000);
        rd = rdata;
    endtask

    typedef struct packed {
        logic [1:0]  op;
        logic [6:0]  len;
        logic [63:0] tdi;
        logic [63:0] exp;
        logic [6:0]  nbits;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 7'd0,   64'h0,                   64'h0,                   7'd0 },  // reset (R3)
        '{2'd2, 7'd8,   64'h0,                   IDC,                     7'd32},  // R8 forced IDCODE
        '{2'd1, 7'd4,   64'h3,                   64'h5,                   7'd4 },  // select user reg
        '{2'd2, 7'd16,  64'hA5C3,                64'h0,                   7'd16},
        '{2'd2, 7'd16,  64'h1E2D,                64'hA5C3,                7'd16},  // R7 value kept
        '{2'd1, 7'd4,   64'hF,                   64'h5,                   7'd4 },  // bypass
        '{2'd2, 7'd1,   64'h1,                   64'h0,                   7'd1 },
        '{2'd2, 7'd64,  64'hDEAD_BEEF_0123_4567, 64'hBD5B_7DDE_0246_8ACE, 7'd64},
        '{2'd2, 7'd13,  64'h1ABC,                64'h1578,                7'd13},
        '{2'd2, 7'd0,   64'h1,                   64'h0,                   7'd1 },  // R9 zero length
        '{2'd2, 7'd100, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFE, 7'd64},  // R9 clamp
        '{2'd1, 7'd4,   64'h3,                   64'h5,                   7'd4 },
        '{2'd2, 7'd16,  64'h0,                   64'h1E2D,                7'd16},
        '{2'd0, 7'd0,   64'h0,                   64'h0,                   7'd0 },
        '{2'd2, 7'd40,  64'h0,                   IDC,                     7'd32},  // R8
        '{2'd2, 7'd32,  64'h0,                   IDC,                     7'd32},  // R8 persists
        '{2'd1, 7'd4,   64'h1,                   64'h5,                   7'd4 },
        '{2'd2, 7'd8,   64'h0,                   64'hDF,                  7'd8 }   // R8 cleared
    };

    initial begin
        repeat (WDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", WDOG, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] rd;
        bit          to;
        int          exp_rise;
        int          busy_seen;
        int          done_seen;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(tck == 1'b1 && tms == 1'b1 && tdi == 1'b0, "R1", "pins after reset",
              {61'd0, tck, tms, tdi}, 64'h6);
        check(busy == 1'b0 && done == 1'b0, "R1", "busy/done after reset",
              {62'd0, busy, done}, 64'h0);
        check(rdata == 64'h0, "R1", "rdata after reset", rdata, 64'h0);

        for (int i = 0; i < NV; i++) begin
            run_op(VECS[i].op, VECS[i].len, VECS[i].tdi, rd, to);
            check(!to, "R10", $sformatf("vector %0d completion", i), {63'd0, to}, 64'h0);
            if (VECS[i].op == 2'd0) begin
                exp_rise = 6;
                check(tms_hist[5:0] == 6'b111110, "R3", $sformatf("vector %0d reset TMS", i),
                      {58'd0, tms_hist[5:0]}, 64'h3E);
            end else if (VECS[i].op == 2'd1) begin
                exp_rise = 6 + int'(VECS[i].nbits);
            end else begin
                exp_rise = 5 + int'(VECS[i].nbits);
            end
            check(rise_cnt == exp_rise, (VECS[i].op == 2'd1) ? "R4" : "R5",
                  $sformatf("vector %0d TCK rises", i), 64'(rise_cnt), 64'(exp_rise));
            check(ts == S_RTI, (VECS[i].op == 2'd1) ? "R4" : "R5",
                  $sformatf("vector %0d final TAP state", i), 64'(ts), 64'(S_RTI));
            check(shift_cnt == int'(VECS[i].nbits),
                  (i == 9 || i == 10) ? "R9" : ((i == 1 || i == 14 || i == 15) ? "R8" : "R7"),
                  $sformatf("vector %0d shift count", i), 64'(shift_cnt), 64'(VECS[i].nbits));
            check(rd == VECS[i].exp, (i == 1 || i == 14 || i == 15 || i == 17) ? "R8" : "R6",
                  $sformatf("vector %0d rdata", i), rd, VECS[i].exp);
            if (i == 7) begin
                check(period == DIV, "R2", "TCK period in clocks", 64'(period), 64'(DIV));
            end
        end

        // R10: command while busy is ignored; user register selected again first
        run_op(2'd1, 7'd4, 64'h3, rd, to);
        @(negedge clk);
        rise_cnt = 0; shift_cnt = 0;
        cmd_valid = 1'b1; cmd_op = 2'd2; cmd_len = 7'd16; cmd_tdi = 64'h7A19;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (20) @(negedge clk);
        check(busy == 1'b1, "R10", "busy during scan", {63'd0, busy}, 64'h1);
        cmd_valid = 1'b1; cmd_op = 2'd1; cmd_len = 7'd4; cmd_tdi = 64'hF;
        @(negedge clk);
        cmd_valid = 1'b0;
        done_seen = 0;
        for (int t = 0; t < 400; t++) begin
            @(negedge clk);
            if (done) done_seen++;
        end
        check(done_seen == 1, "R10", "done pulses for one scan", 64'(done_seen), 64'h1);
        check(rise_cnt == 21, "R10", "rises with ignored command", 64'(rise_cnt), 64'd21);
        run_op(2'd2, 7'd16, 64'h0, rd, to);
        check(rd == 64'h7A19, "R10", "user reg after ignored IR", rd, 64'h7A19);

        // R10: op code 3 is not accepted
        @(negedge clk);
        rise_cnt = 0;
        cmd_valid = 1'b1; cmd_op = 2'd3; cmd_len = 7'd8;
        @(negedge clk);
        cmd_valid = 1'b0;
        busy_seen = 0;
        for (int t = 0; t < 50; t++) begin
            @(negedge clk);
            if (busy) busy_seen++;
        end
        check(busy_seen == 0 && rise_cnt == 0, "R10", "op 3 ignored",
              64'(busy_seen + rise_cnt), 64'h0);
        check(tck == 1'b1, "R1", "TCK idle high", {63'd0, tck}, 64'h1);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule